// File: doc/BRIEF.md
# Resynchronizing Bit-Clock Recovery Divider

This block produces the bit clock that travels beside a demodulated FSK data stream, so that an external controller can sample each bit. It watches the squared FSK carrier, counts its rising edges, and divides them by sixteen. In steady state each bit spans sixteen carrier cycles, and the bit clock rises four carrier cycles into every bit, which puts the sampling edge well inside the bit window.

Noise can add or remove carrier cycles and shift the bit boundaries. To pull the clock back into line, the demodulator's decided-bit signal is watched. Whenever that bit rises from 0 to 1, the cycle counter is cleared and the clock is driven low. A falling decided bit leaves the counter alone. The divider keeps running whether or not data is changing, so it also runs while the link is transmitting and the decided bit is held.

The squared carrier is asynchronous and passes through a synchronizer before its rising edges are detected. The decided bit is synchronous to the master clock.

Top module: `bit_clock_recovery`

## Requirements
- R1: While `rst` is high at a rising clock edge, the internal cycle phase becomes 0 and `bit_clk` becomes 0.
- R2: Each detected rising edge of `fsk_in` advances the phase by one, and the phase wraps from 15 to 0. With no resync, the `bit_clk` pattern therefore repeats every 16 carrier edges.
- R3: `bit_clk` is 1 exactly when the phase is in the range 4 to 11, so its high time is 8 carrier cycles and its low time is 8 carrier cycles.
- R4: After a resync, `bit_clk` stays 0 for the next three carrier edges and rises on the fourth.
- R5: When `bit_in` is 1 at a clock edge and was 0 at the previous edge, the phase becomes 0 and `bit_clk` becomes 0 at that edge, whatever the phase was before. If a carrier edge lands in the same cycle, the resync takes priority.
- R6: A 1-to-0 change of `bit_in` does not clear or move the phase. The `bit_clk` sequence continues as if no change had occurred.
- R7: While `bit_in` is held constant at either level (as during transmit), the divider keeps counting carrier edges according to R2 and R3.
- R8: A rising edge of `fsk_in`, applied between master-clock edges, changes the phase on the third rising master-clock edge after it, through two synchronizer flops and one state flop. With no carrier edge and no resync, `bit_clk` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| fsk_in | input | 1 | Squared FSK carrier, asynchronous; rising edges are counted |
| bit_in | input | 1 | Decided data bit from the demodulator, synchronous to `clk` |
| bit_clk | output | 1 | Recovered bit clock |

## Verification
The phase counter is hidden, so any fault in it shows only through `bit_clk`. If the counter skips or repeats a count, the high or low run stretches or shrinks, and the fault shows within one 16-edge period. If the resync is missed, or fires on a falling bit, the next rising `bit_clk` edge moves away from the fourth carrier edge after the data change. After every carrier edge and every bit change, the bench compares `bit_clk` with a phase model. This catches each such fault on the first edge where the phase disagrees.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    // Divider state carried between stages
    typedef struct packed {
        logic [7:0] phase;
        logic       clk_level;
    } div_state_t;

    // High window of the recovered clock: lead <= phase < lead + div/2
    function automatic logic phase_is_high(input int unsigned phase,
                                           input int unsigned lead,
                                           input int unsigned div);
        return (phase >= lead) && (phase < lead + div / 2);
    endfunction

    function automatic int unsigned phase_step(input int unsigned phase,
                                               input int unsigned div);
        return (phase == div - 1) ? 0 : phase + 1;
    endfunction

endpackage

// File: rtl/bclk_edge_sync.sv
module bclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_pulse
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        for (genvar g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/bclk_bit_watch.sv
module bclk_bit_watch (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic up_pulse,
    output logic down_pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= bit_in;
    end

    assign up_pulse   = bit_in & ~prev_q;
    assign down_pulse = ~bit_in & prev_q;
endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
    import bclk_pkg::*;
#(
    parameter int DIV  = 16,
    parameter int LEAD = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     advance,
    input  logic                     resync,
    output logic [$clog2(DIV)-1:0]   phase,
    output logic                     clk_out
);
    localparam int CW = $clog2(DIV);

    div_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (resync) begin
            st_d.phase     = '0;
            st_d.clk_level = 1'b0;
        end else if (advance) begin
            st_d.phase     = 8'(phase_step(int'(st_q.phase), DIV));
            st_d.clk_level = phase_is_high(int'(st_d.phase), LEAD, DIV);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase   = st_q.phase[CW-1:0];
    assign clk_out = st_q.clk_level;

    // R3: a rising clock only ever starts at the lead phase
    a_r3_rise_at_lead: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> int'(phase) == LEAD);
endmodule

// File: rtl/bit_clock_recovery.sv
module bit_clock_recovery #(
    parameter int DIV         = 16,
    parameter int LEAD        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fsk_in,
    input  logic bit_in,
    output logic bit_clk
);
    localparam int CW = $clog2(DIV);

    logic          edge_p;
    logic          up_p;
    logic          down_p;
    logic [CW-1:0] phase;

    bclk_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .din(fsk_in), .rise_pulse(edge_p)
    );

    bclk_bit_watch i_watch (
        .clk(clk), .rst(rst), .bit_in(bit_in),
        .up_pulse(up_p), .down_pulse(down_p)
    );

    bclk_divider #(.DIV(DIV), .LEAD(LEAD)) i_div (
        .clk(clk), .rst(rst), .advance(edge_p), .resync(up_p),
        .phase(phase), .clk_out(bit_clk)
    );

    // R5: a rising decided bit clears the phase and forces the clock low
    a_r5_resync_clear: assert property (@(posedge clk) disable iff (rst)
        up_p |=> (phase == '0) && !bit_clk);

    // R2: one step per carrier edge, wrapping at DIV
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (edge_p && !up_p) |=> int'(phase) == ((int'($past(phase)) + 1) % DIV));

    // R8: nothing moves without a carrier edge or resync
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!edge_p && !up_p) |=> $stable(phase) && $stable(bit_clk));

    // R6: a falling decided bit leaves the phase untouched
    a_r6_fall_ignored: assert property (@(posedge clk) disable iff (rst)
        (down_p && !edge_p) |=> $stable(phase));
endmodule

// File: tb/test_bit_clock_recovery.sv
module test_bit_clock_recovery;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 16;
    localparam int LEAD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsk_in = 1'b0;
    logic bit_in = 1'b0;
    logic bit_clk;

    int n_cmp = 0;
    int n_bad = 0;
    int m = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bit_clock_recovery #(.DIV(DIV), .LEAD(LEAD), .SYNC_STAGES(2)) i_bit_clock_recovery (
        .clk(clk), .rst(rst), .fsk_in(fsk_in), .bit_in(bit_in), .bit_clk(bit_clk)
    );

    function automatic logic exp_clk(int ph);
        return (ph >= LEAD) && (ph < LEAD + DIV / 2);
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: bit_clk actual=%0b expected=%0b (model phase %0d)", req, act, exp, m);
        end
    endtask

    // One carrier cycle; returns at a negedge after the edge has propagated
    task automatic wave(int hi, int lo);
        @(negedge clk) fsk_in = 1'b1;
        repeat (hi) @(negedge clk);
        fsk_in = 1'b0;
        repeat (lo - 1) @(negedge clk);
        m = (m + 1) % DIV;
    endtask

    task automatic set_bit(logic v);
        @(negedge clk);
        if (v && !bit_in) m = 0;
        bit_in = v;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5eed_0b1c));
        repeat (3) @(negedge clk);
        check("R1 during reset", bit_clk, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", bit_clk, 1'b0);

        // R2 R3 R4: clean 16-wave bits from phase 0, two full periods
        for (int i = 0; i < 2 * DIV; i++) begin
            wave(8, 8);
            check("R2/R3 clean period", bit_clk, exp_clk(m));
        end

        // R8: exact latency of a carrier edge (phase 0 -> 3, next edge rises)
        for (int i = 0; i < 3; i++) wave(4, 4);
        @(negedge clk) fsk_in = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R8 no change before third edge", bit_clk, 1'b0);
        @(posedge clk); #1;
        check("R8 change on third edge", bit_clk, 1'b1);
        m = 4;
        @(negedge clk) fsk_in = 1'b0;
        repeat (3) @(negedge clk);

        // R8: hold without carrier edges
        repeat (20) @(negedge clk);
        check("R8 hold without edges", bit_clk, exp_clk(m));

        // R5 R4: rising bit at several arbitrary phases, then four edges to the first rise
        for (int k = 0; k < 6; k++) begin
            int pre = $urandom_range(1, 20);
            for (int i = 0; i < pre; i++) wave(3, 3);
            set_bit(1'b1);
            check("R5 resync forces low", bit_clk, 1'b0);
            for (int i = 0; i < 3; i++) begin
                wave(3, 4);
                check("R4 low before fourth edge", bit_clk, 1'b0);
            end
            wave(3, 4);
            check("R4 rise on fourth edge", bit_clk, 1'b1);
            // R6: falling bit at an arbitrary phase changes nothing
            pre = $urandom_range(0, 9);
            for (int i = 0; i < pre; i++) wave(2, 3);
            set_bit(1'b0);
            check("R6 falling bit ignored", bit_clk, exp_clk(m));
            for (int i = 0; i < 5; i++) begin
                wave(3, 3);
                check("R6 sequence continues", bit_clk, exp_clk(m));
            end
        end

        // R7: bit held high, divider keeps running
        set_bit(1'b1);
        for (int i = 0; i < 40; i++) begin
            wave($urandom_range(2, 6), $urandom_range(2, 6));
            check("R7 bit held high", bit_clk, exp_clk(m));
        end

        // Random mix of carrier cycles and bit changes
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                set_bit(~bit_in);
                check("R5/R6 random bit change", bit_clk, exp_clk(m));
            end else begin
                wave($urandom_range(2, 9), $urandom_range(2, 9));
                check("R2/R3 random carrier", bit_clk, exp_clk(m));
            end
        end

        // R1: reset in mid-run returns to phase 0, low
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", bit_clk, 1'b0);
        bit_in = 1'b0;
        rst = 1'b0;
        m = 0;
        for (int i = 0; i < 5; i++) wave(3, 3);
        check("R1 restart from phase 0", bit_clk, exp_clk(m));

        done = 1'b1;
        summary();
    end
endmodule